// File: doc/BRIEF.md
# Serial Flash Write-Enable Gating Front End

This block is the command front end of a serial flash device. It watches the serial bus (chip select, serial clock and data in), collects each command's opcode, and, for the single status write command, the data byte. When chip select returns high, it decides whether the command is allowed. Two enable flags drive that decision. The first is a write-enable latch, which every program, erase and non-volatile status write needs. The second is a one-shot volatile-enable flag, which lets the next status write change only the working copy of the status bits.

The status value has two copies. One is a non-volatile copy, standing in for the stored bits. The other is a volatile working copy, which is the copy reported to the outside. A status write armed by the volatile path changes only the working copy. A status write armed by the write-enable latch changes both copies and counts as a non-volatile write. Every decision appears as a one-cycle strobe: accept or reject for program, accept or reject for erase, and non-volatile accept, volatile accept or reject for the status write.

The serial inputs are sampled with the system clock. The serial clock must stay at or below half the system clock rate. The serial data output is never driven by this block, because none of its commands return data. Program and erase commands are handled here as opcode-only frames.

Top module: `flashCmdFrontEnd`

## Requirements
- R1: Bits enter MSB-first on rising serial-clock edges while chip select is low. A command takes effect in the system-clock cycle after chip select rises. Serial-clock edges while chip select is high change nothing.
- R2: Opcode 06h in an 8-clock frame sets the write-enable latch, which reads back as status bit 1. Status bit 0 always reads 0.
- R3: Opcodes 02h (program), 20h and D8h (erase) and C7h and 60h (erase) in an 8-clock frame are accepted only when the latch is 1. An accepted command pulses its class accept strobe and clears the latch. A refused command pulses its class reject strobe, and the latch stays 0.
- R4: Opcode 04h in an 8-clock frame clears the write-enable latch and pulses no strobe.
- R5: Opcode 50h in an 8-clock frame arms the volatile-enable flag. It leaves the latch, both status copies and all strobes unchanged.
- R6: Opcode 01h in a 16-clock frame with the volatile-enable flag armed works as follows. It copies data bits 7:2 into status bits 7:2 of the working copy, pulses the volatile accept strobe and disarms the flag. It leaves the non-volatile copy and the latch unchanged. This path wins when the latch is also set.
- R7: Opcode 01h in a 16-clock frame with only the latch set writes data bits 7:2 into both copies, pulses the non-volatile accept strobe and clears the latch. With neither flag set, it pulses the status reject strobe and changes nothing.
- R8: A frame whose clock count differs from the required count is discarded, with no strobe and no change to any flag or copy. The required count is 16 for opcode 01h and 8 for every other opcode.
- R9: Every completed frame other than 50h disarms the volatile-enable flag. This includes unknown opcodes and refused commands.
- R10: Reset clears the latch and the volatile-enable flag, loads both copies with NV_INIT bits 7:2 and holds all strobes low.
- R11: Both serial-clock idle-low and idle-high framing give identical results.
- R12: At most one strobe pulses per frame, each for exactly one system-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiClk | input | 1 | Serial clock, sampled by clk |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data in |
| progAccept | output | 1 | Program command accepted |
| progReject | output | 1 | Program command refused |
| eraseAccept | output | 1 | Erase command accepted |
| eraseReject | output | 1 | Erase command refused |
| statusNvAccept | output | 1 | Status write accepted into both copies |
| statusVolAccept | output | 1 | Status write accepted into working copy only |
| statusReject | output | 1 | Status write refused |
| statusValue | output | 8 | Working status: bits 7:2, latch at bit 1, 0 at bit 0 |
| nvBits | output | 6 | Non-volatile copy of status bits 7:2 |

## Verification
The bench sends all 256 opcodes from four prior flag states: latch clear, latch set, both flags armed, and only the volatile flag armed. It alternates idle-low and idle-high framing, and compares each frame against a flag-level model. A design that gave the latch priority over the volatile flag would write the non-volatile copy after 06h followed by 50h. A design that left the volatile flag armed across other commands would accept a later status write that should be refused. Short, long and mismatched clock counts are sent to catch a design that decodes an opcode before framing is complete. Serial clocks sent with chip select high must leave the state untouched, and a reset after a volatile write must restore the working copy.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  localparam logic [7:0] OP_LATCH_SET  = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR  = 8'h04;
  localparam logic [7:0] OP_VOL_ARM    = 8'h50;
  localparam logic [7:0] OP_STAT_WRITE = 8'h01;
  localparam logic [7:0] OP_PROGRAM    = 8'h02;
  localparam logic [7:0] OP_ERASE_SMALL = 8'h20;
  localparam logic [7:0] OP_ERASE_LARGE = 8'hD8;
  localparam logic [7:0] OP_ERASE_ALL_A = 8'hC7;
  localparam logic [7:0] OP_ERASE_ALL_B = 8'h60;

  typedef enum logic [2:0] {
    CLS_OTHER, CLS_PROG, CLS_ERASE, CLS_STATUS, CLS_LSET, CLS_LCLR, CLS_VARM
  } cmdClass_t;

  // control -> datapath strobes
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setVwe;
    logic clrVwe;
    logic wrVol;
    logic wrNv;
  } ctrlStrobes_t;

  typedef struct packed {
    logic progOk;
    logic progRej;
    logic eraseOk;
    logic eraseRej;
    logic nvOk;
    logic volOk;
    logic stRej;
  } cmdResult_t;

  function automatic cmdClass_t classify(input logic [7:0] op);
    case (op)
      OP_PROGRAM:                                     classify = CLS_PROG;
      OP_ERASE_SMALL, OP_ERASE_LARGE,
      OP_ERASE_ALL_A, OP_ERASE_ALL_B:                 classify = CLS_ERASE;
      OP_STAT_WRITE:                                  classify = CLS_STATUS;
      OP_LATCH_SET:                                   classify = CLS_LSET;
      OP_LATCH_CLR:                                   classify = CLS_LCLR;
      OP_VOL_ARM:                                     classify = CLS_VARM;
      default:                                        classify = CLS_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/flashCmdDatapath.sv
module flashCmdDatapath
  import flashCmdPkg::*;
#(
  parameter int OP_BITS = 8,
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] NV_INIT = '0,
  localparam int FRAME_LONG = OP_BITS + STAT_W,
  localparam int CNT_W = $clog2(FRAME_LONG + 2),
  localparam int WR_LO = 2,
  localparam int WR_W = STAT_W - WR_LO
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               spiClk,
  input  logic               spiCsN,
  input  logic               spiMosi,
  input  ctrlStrobes_t       ctrl,
  output logic               frameEnd,
  output logic [CNT_W-1:0]   bitCnt,
  output logic [OP_BITS-1:0] opcode,
  output logic               wel,
  output logic               vwe,
  output logic [STAT_W-1:0]  statusOut,
  output logic [WR_W-1:0]    nvBits
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_LONG + 1);
  localparam logic [CNT_W-1:0] OP_LAST = CNT_W'(OP_BITS - 1);

  logic              sclkPrev;
  logic              csPrev;
  logic              sclkRise;
  logic [STAT_W-1:0] shiftReg;
  logic [WR_W-1:0]   volBits;

  assign sclkRise = spiClk & ~sclkPrev & ~spiCsN;
  assign frameEnd = spiCsN & ~csPrev;

  // serial capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
      bitCnt   <= '0;
      shiftReg <= '0;
      opcode   <= '0;
    end else begin
      sclkPrev <= spiClk;
      csPrev   <= spiCsN;
      if (spiCsN) begin
        bitCnt <= '0;
      end else if (sclkRise && bitCnt != CNT_MAX) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (sclkRise) begin
        shiftReg <= {shiftReg[STAT_W-2:0], spiMosi};
        if (bitCnt == OP_LAST) begin
          opcode <= {shiftReg[OP_BITS-2:0], spiMosi};
        end
      end
    end
  end

  // enable flags and status copies
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel     <= 1'b0;
      vwe     <= 1'b0;
      nvBits  <= NV_INIT[STAT_W-1:WR_LO];
      volBits <= NV_INIT[STAT_W-1:WR_LO];
    end else begin
      if (ctrl.setWel) begin
        wel <= 1'b1;
      end else if (ctrl.clrWel) begin
        wel <= 1'b0;
      end
      if (ctrl.setVwe) begin
        vwe <= 1'b1;
      end else if (ctrl.clrVwe) begin
        vwe <= 1'b0;
      end
      if (ctrl.wrVol) begin
        volBits <= shiftReg[STAT_W-1:WR_LO];
      end
      if (ctrl.wrNv) begin
        nvBits <= shiftReg[STAT_W-1:WR_LO];
      end
    end
  end

  assign statusOut = {volBits, wel, 1'b0};

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (spiCsN && csPrev) |=> $stable(statusOut)); // R1
  AST_ARM_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.setVwe |=> (wel == $past(wel))); // R5
  AST_VOL_KEEPS_NV: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrVol && !ctrl.wrNv) |=> $stable(nvBits)); // R6

endmodule

// File: rtl/flashCmdControl.sv
module flashCmdControl
  import flashCmdPkg::*;
#(
  parameter int OP_BITS = 8,
  parameter int DATA_BITS = 8,
  parameter int CNT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameEnd,
  input  logic [CNT_W-1:0]   bitCnt,
  input  logic [OP_BITS-1:0] opcode,
  input  logic               wel,
  input  logic               vwe,
  output ctrlStrobes_t       ctrl,
  output cmdResult_t         result
);

  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(OP_BITS);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(OP_BITS + DATA_BITS);

  cmdClass_t  cls;
  logic       lenOk;
  cmdResult_t resNext;

  assign cls   = classify(opcode);
  assign lenOk = (cls == CLS_STATUS) ? (bitCnt == LEN_LONG) : (bitCnt == LEN_SHORT);

  always_comb begin
    ctrl    = '0;
    resNext = '0;
    if (frameEnd && lenOk) begin
      ctrl.clrVwe = (cls != CLS_VARM);
      case (cls)
        CLS_LSET: ctrl.setWel = 1'b1;
        CLS_LCLR: ctrl.clrWel = 1'b1;
        CLS_VARM: ctrl.setVwe = 1'b1;
        CLS_PROG: begin
          if (wel) begin
            resNext.progOk = 1'b1;
            ctrl.clrWel    = 1'b1;
          end else begin
            resNext.progRej = 1'b1;
          end
        end
        CLS_ERASE: begin
          if (wel) begin
            resNext.eraseOk = 1'b1;
            ctrl.clrWel     = 1'b1;
          end else begin
            resNext.eraseRej = 1'b1;
          end
        end
        CLS_STATUS: begin
          if (vwe) begin
            ctrl.wrVol    = 1'b1;
            resNext.volOk = 1'b1;
          end else if (wel) begin
            ctrl.wrVol   = 1'b1;
            ctrl.wrNv    = 1'b1;
            ctrl.clrWel  = 1'b1;
            resNext.nvOk = 1'b1;
          end else begin
            resNext.stRej = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
    end else begin
      result <= resNext;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(result)); // R12
  AST_ACCEPT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    (result.progOk || result.eraseOk) |-> $past(wel)); // R3
  AST_VOL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    result.volOk |-> $past(vwe)); // R6

endmodule

// File: rtl/flashCmdFrontEnd.sv
module flashCmdFrontEnd
  import flashCmdPkg::*;
#(
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] NV_INIT = 8'h3C,
  localparam int OP_BITS = 8,
  localparam int WR_W = STAT_W - 2,
  localparam int CNT_W = $clog2(OP_BITS + STAT_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiClk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              progAccept,
  output logic              progReject,
  output logic              eraseAccept,
  output logic              eraseReject,
  output logic              statusNvAccept,
  output logic              statusVolAccept,
  output logic              statusReject,
  output logic [STAT_W-1:0] statusValue,
  output logic [WR_W-1:0]   nvBits
);

  ctrlStrobes_t       ctrl;
  cmdResult_t         result;
  logic               frameEnd;
  logic [CNT_W-1:0]   bitCnt;
  logic [OP_BITS-1:0] opcode;
  logic               wel;
  logic               vwe;

  flashCmdDatapath #(
    .OP_BITS(OP_BITS), .STAT_W(STAT_W), .NV_INIT(NV_INIT)
  ) uPath (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .ctrl(ctrl), .frameEnd(frameEnd), .bitCnt(bitCnt), .opcode(opcode),
    .wel(wel), .vwe(vwe), .statusOut(statusValue), .nvBits(nvBits)
  );

  flashCmdControl #(
    .OP_BITS(OP_BITS), .DATA_BITS(STAT_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .bitCnt(bitCnt),
    .opcode(opcode), .wel(wel), .vwe(vwe), .ctrl(ctrl), .result(result)
  );

  assign progAccept      = result.progOk;
  assign progReject      = result.progRej;
  assign eraseAccept     = result.eraseOk;
  assign eraseReject     = result.eraseRej;
  assign statusNvAccept  = result.nvOk;
  assign statusVolAccept = result.volOk;
  assign statusReject    = result.stRej;

endmodule

// File: tb/tb_flashCmdFrontEnd.sv
module tb_flashCmdFrontEnd;

  localparam logic [7:0] NV_INIT = 8'h3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiClk = 1'b0;
  logic spiCsN = 1'b1;
  logic spiMosi = 1'b0;
  logic progAccept, progReject, eraseAccept, eraseReject;
  logic statusNvAccept, statusVolAccept, statusReject;
  logic [7:0] statusValue;
  logic [5:0] nvBits;

  always #5 clk = ~clk;

  flashCmdFrontEnd #(.STAT_W(8), .NV_INIT(NV_INIT)) dut (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .progAccept(progAccept), .progReject(progReject),
    .eraseAccept(eraseAccept), .eraseReject(eraseReject),
    .statusNvAccept(statusNvAccept), .statusVolAccept(statusVolAccept),
    .statusReject(statusReject), .statusValue(statusValue), .nvBits(nvBits)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // model state
  bit welM, vweM;
  logic [5:0] volM, nvM;
  logic [6:0] expStrobe;
  logic [6:0] gotStrobe;

  function automatic logic [6:0] strobes();
    return {progAccept, progReject, eraseAccept, eraseReject,
            statusNvAccept, statusVolAccept, statusReject};
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [7:0] op, input int nbits);
    bit longOp = (op == 8'h01);
    if ((longOp && nbits != 16) || (!longOp && nbits != 8)) return "R8";
    case (op)
      8'h06: return "R2";
      8'h04: return "R4";
      8'h50: return "R5";
      8'h01: return "R6_R7";
      8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60: return "R3";
      default: return "R9";
    endcase
  endfunction

  // strobe bits: [6]prog ok [5]prog rej [4]erase ok [3]erase rej [2]nv ok [1]vol ok [0]status rej
  task automatic modelFrame(input logic [7:0] op, input logic [7:0] data, input int nbits);
    bit oldWel = welM;
    bit oldVwe = vweM;
    expStrobe = '0;
    if ((op == 8'h01) ? (nbits != 16) : (nbits != 8)) return;
    vweM = 1'b0;
    case (op)
      8'h06: welM = 1'b1;
      8'h04: welM = 1'b0;
      8'h50: vweM = 1'b1;
      8'h02: begin
        if (oldWel) begin expStrobe = 7'b1000000; welM = 1'b0; end
        else expStrobe = 7'b0100000;
      end
      8'h20, 8'hD8, 8'hC7, 8'h60: begin
        if (oldWel) begin expStrobe = 7'b0010000; welM = 1'b0; end
        else expStrobe = 7'b0001000;
      end
      8'h01: begin
        if (oldVwe) begin volM = data[7:2]; expStrobe = 7'b0000010; end
        else if (oldWel) begin
          volM = data[7:2]; nvM = data[7:2]; welM = 1'b0; expStrobe = 7'b0000100;
        end else expStrobe = 7'b0000001;
      end
      default: ;
    endcase
  endtask

  // frame: bits[nbits-1] first; mode3 = idle-high serial clock
  task automatic sendFrame(input logic [15:0] bits, input int nbits, input bit mode3, input string tag);
    @(negedge clk) spiClk = mode3;
    @(negedge clk) spiCsN = 1'b0;
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk) begin spiClk = 1'b0; spiMosi = bits[i]; end
      @(negedge clk) spiClk = 1'b1;
    end
    @(negedge clk) spiClk = mode3;
    @(negedge clk) spiCsN = 1'b1;
    @(posedge clk);
    #1;
    gotStrobe = strobes();
    check(tag, "strobes", {9'd0, gotStrobe}, {9'd0, expStrobe});
    check(tag, "status", {8'd0, statusValue}, {8'd0, volM, welM, 1'b0});
    check(tag, "nvBits", {10'd0, nvBits}, {10'd0, nvM});
    @(posedge clk);
    #1;
    check("R12", "strobe width", {9'd0, strobes()}, 16'd0);
  endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] data, input int nbits, input bit mode3);
    logic [15:0] bits;
    if (nbits > 8) bits = {op, data} >> (16 - nbits);
    else bits = {8'd0, op} >> (8 - nbits);
    modelFrame(op, data, nbits);
    sendFrame(bits, nbits, mode3, tagOf(op, nbits));
  endtask

  task automatic doReset();
    @(negedge clk) begin rstN = 1'b0; spiCsN = 1'b1; spiClk = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    welM = 1'b0; vweM = 1'b0; volM = NV_INIT[7:2]; nvM = NV_INIT[7:2];
    #1;
    check("R10", "reset status", {8'd0, statusValue}, {8'd0, NV_INIT[7:2], 2'b00});
    check("R10", "reset nv", {10'd0, nvBits}, {10'd0, NV_INIT[7:2]});
    check("R10", "reset strobes", {9'd0, strobes()}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset();

    // R11: opcode sweep alternating idle-low / idle-high framing from four prior flag states
    for (int op = 0; op < 256; op++) begin
      for (int pre = 0; pre < 4; pre++) begin
        bit m3 = op[0] ^ pre[0];
        logic [7:0] dat = 8'(op * 37 + pre * 91);
        case (pre)
          0: cmd(8'h04, 8'h00, 8, m3);
          1: cmd(8'h06, 8'h00, 8, m3);
          2: begin cmd(8'h06, 8'h00, 8, m3); cmd(8'h50, 8'h00, 8, ~m3); end
          default: begin cmd(8'h04, 8'h00, 8, m3); cmd(8'h50, 8'h00, 8, ~m3); end
        endcase
        cmd(8'(op), dat, (op == 1) ? 16 : 8, m3);
        if (pre == 3) cmd(8'h01, ~dat, 16, ~m3); // R9 volatile flag consumed or disarmed
      end
    end

    // R8: wrong clock counts discard the frame
    cmd(8'h06, 8'h00, 8, 1'b0);
    cmd(8'h02, 8'h00, 7, 1'b0);
    cmd(8'h02, 8'h80, 9, 1'b1);
    cmd(8'h01, 8'hFF, 8, 1'b0);
    cmd(8'h01, 8'hA4, 15, 1'b1);
    cmd(8'h50, 8'h80, 9, 1'b0);
    cmd(8'h01, 8'h00, 16, 1'b0); // must take the latch path: flag was never armed
    cmd(8'h06, 8'h00, 8, 1'b1);
    cmd(8'h20, 8'h00, 8, 1'b0);

    // R1: serial clocks with chip select high change nothing
    cmd(8'h06, 8'h00, 8, 1'b0);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk) begin spiClk = ~spiClk; spiMosi = i[1]; end
      #1;
      check("R1", "strobes cs high", {9'd0, strobes()}, 16'd0);
    end
    check("R1", "status cs high", {8'd0, statusValue}, {8'd0, volM, welM, 1'b0});
    cmd(8'h02, 8'h00, 8, 1'b0);

    // R6 priority then R10 reset restores working copy
    cmd(8'h06, 8'h00, 8, 1'b0);
    cmd(8'h50, 8'h00, 8, 1'b1);
    cmd(8'h01, 8'hC3, 16, 1'b0);
    check("R6", "nv untouched", {10'd0, nvBits}, {10'd0, nvM});
    doReset();
    cmd(8'h01, 8'hFF, 16, 1'b1); // R7 reject after reset

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule